// File: doc/BRIEF.md
# Link-On Wake Signal Generator

This block lives in a serial-bus physical-layer controller. It drives a wake line toward an attached link-layer controller while that controller is powered down. Several wake sources are combined, but only while the link is idle. The link is idle when its power-status input is low or its control bit is clear. While any source holds, the line carries a square wave. Otherwise the line is driven low.

Each source is cleared in its own way. A received link-on packet is latched, and a bus reset cancels it. Interrupt-driven wake follows the current levels of the interrupt bits, so an interrupt that is pending while the link is busy raises the wake line as soon as the link goes idle. A qualifying power-cycle event is latched and runs a timeout, so a wake with no other cause ends on its own.

During hardware reset the line is released (output enable low). The pad level is sampled as a mode strap, and the block holds that value after reset.

Top module: `lkon_wake_gen`

## Requirements
- R1: While `hw_rst_n` is low, `wake_oe` is 0 and `wake_out` is 0. From the first cycle after release, `wake_oe` is 1.
- R2: `strap_legacy` holds the `pad_in` level seen at the last clock edge of hardware reset, and it stays constant until the next reset. Value 1 selects legacy-only port mode and value 0 selects bilingual port mode.
- R3: The link counts as busy when `link_pwr_on` and `link_ctrl_bit` are both 1. No source activates the wake line after an edge at which the link was sampled busy.
- R4: The wake sources are:
  - a `pkt_wake_pulse`;
  - `irq_port_evt` at 1;
  - any of `irq_cfg_tmo`, `irq_cbl_pwr` or `irq_state_tmo` at 1 while `irq_resume_en` is 1;
  - a `pwr_cycle_evt` with `pwr_class` from 0 to MAX_WAKE_CLASS (default 4).

  A class above that limit is ignored.
- R5: While active, `wake_out` repeats with a period of WAVE_PERIOD cycles (default 8), high for the first half and low for the second. Each new activation starts with the high half in the first active cycle, which is the cycle after the edge that samples the source.
- R6: A bus reset cancels a latched packet wake. The wake line keeps running without a phase break when an interrupt source or a power-cycle wake still holds.
- R7: When the link is sampled busy at an edge, `wake_out` is 0 from that edge onward.
- R8: An interrupt source that is held while the link is busy activates the wake line at the first edge where the link is sampled idle.
- R9: A wake from power-cycling alone stays active for exactly PC_TIMEOUT cycles and then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous |
| link_pwr_on | input | 1 | Link power-status input, 1 = powered |
| link_ctrl_bit | input | 1 | Link-control register bit |
| pkt_wake_pulse | input | 1 | One-cycle pulse: link-on packet for this node received |
| bus_reset_pulse | input | 1 | One-cycle bus-reset pulse |
| irq_port_evt | input | 1 | Port-event interrupt bit |
| irq_cfg_tmo | input | 1 | Configuration-timeout interrupt bit |
| irq_cbl_pwr | input | 1 | Cable-power-status interrupt bit |
| irq_state_tmo | input | 1 | State-timeout interrupt bit |
| irq_resume_en | input | 1 | Resuming-port interrupt enable |
| pwr_cycle_evt | input | 1 | One-cycle pulse: power-cycle event |
| pwr_class | input | CLASS_W | Power-class code for the power-cycle event |
| pad_in | input | 1 | Pad level, sampled as a strap during reset |
| wake_out | output | 1 | Square-wave wake output |
| wake_oe | output | 1 | Output enable for the tri-state pad |
| strap_legacy | output | 1 | Sampled mode strap, 1 = legacy-only |

## Verification
Some properties are checked on every cycle:
- no activation follows an edge that sampled the link busy;
- a new activation starts at phase zero;
- a bus reset clears the latched packet flag;
- an interrupt held while the link is idle always yields activity;
- the timeout count stays inside its bound;
- the strap does not change after reset.

Other behaviour is shown only by the bench scenarios, which track the waveform cycle by cycle:
- the exact high and low pattern;
- a bus reset that leaves an interrupt wake or a power-cycle wake running with its phase intact;
- a pending interrupt that wakes when the link goes idle;
- the exact length of a power-cycle-only wake;
- a power class above the limit being ignored.

// File: rtl/lkon_pkg.sv
package lkon_pkg;

    typedef enum logic {
        STRAP_BILINGUAL = 1'b0,
        STRAP_LEGACY    = 1'b1
    } strap_mode_e;

    typedef struct packed {
        logic port_evt;
        logic cfg_tmo;
        logic cbl_pwr;
        logic state_tmo;
        logic resume_en;
    } irq_bits_t;

    function automatic logic irq_qualifies(irq_bits_t b);
        return b.port_evt | (b.resume_en & (b.cfg_tmo | b.cbl_pwr | b.state_tmo));
    endfunction

endpackage

// File: rtl/lkon_strap.sv
module lkon_strap
    import lkon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pad_in,
    output strap_mode_e strap_mode,
    output logic        pad_oe
);

    strap_mode_e strap_d, strap_q;

    always_comb begin
        strap_d = strap_q;
        if (!rst_n) strap_d = strap_mode_e'(pad_in);
    end

    always_ff @(posedge clk) begin
        strap_q <= strap_d;
    end

    assign strap_mode = strap_q;
    assign pad_oe     = rst_n;

    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q))
        else $error("strap changed after reset");

endmodule

// File: rtl/lkon_src.sv
module lkon_src
    import lkon_pkg::*;
#(
    parameter int PC_TIMEOUT     = 40,
    parameter int CLASS_W        = 3,
    parameter int MAX_WAKE_CLASS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_idle,
    input  logic               pkt_pulse,
    input  logic               bus_rst,
    input  irq_bits_t          irq,
    input  logic               pc_evt,
    input  logic [CLASS_W-1:0] pc_class,
    output logic               irq_wake,
    output logic               wake_req
);

    localparam int CW = (PC_TIMEOUT > 1) ? $clog2(PC_TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(PC_TIMEOUT - 1);

    typedef struct packed {
        logic          pkt;
        logic          pc;
        logic [CW-1:0] cnt;
    } src_state_t;

    src_state_t s_d, s_q;
    logic       class_ok;

    always_comb begin
        irq_wake = irq_qualifies(irq);
        class_ok = (pc_class <= CLASS_W'(MAX_WAKE_CLASS));
        s_d      = s_q;
        if (!link_idle) begin
            s_d.pkt = 1'b0;
            s_d.pc  = 1'b0;
            s_d.cnt = '0;
        end else begin
            if (bus_rst)   s_d.pkt = 1'b0;
            if (pkt_pulse) s_d.pkt = 1'b1;
            if (s_q.pc) begin
                if (s_q.cnt == LAST) begin
                    s_d.pc  = 1'b0;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (pc_evt && class_ok) begin
                s_d.pc  = 1'b1;
                s_d.cnt = '0;
            end
        end
        wake_req = link_idle & (s_d.pkt | s_d.pc | irq_wake);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_busrst_clears_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && !pkt_pulse) |=> !s_q.pkt)
        else $error("packet wake survived bus reset");

    assert_pkt_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_pulse && link_idle) |=> s_q.pkt)
        else $error("packet wake not latched");

    assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST)
        else $error("power-cycle counter out of range");

endmodule

// File: rtl/lkon_wave.sv
module lkon_wave #(
    parameter int WAVE_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active,
    output logic level
);

    localparam int PW   = (WAVE_PERIOD > 2) ? $clog2(WAVE_PERIOD) : 1;
    localparam int HALF = WAVE_PERIOD / 2;
    localparam logic [PW-1:0] PH_LAST = PW'(WAVE_PERIOD - 1);

    typedef struct packed {
        logic          act;
        logic [PW-1:0] ph;
    } wave_state_t;

    wave_state_t w_d, w_q;

    always_comb begin
        w_d.act = req;
        if (req && w_q.act) begin
            w_d.ph = (w_q.ph == PH_LAST) ? '0 : w_q.ph + 1'b1;
        end else begin
            w_d.ph = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign active = w_q.act;
    assign level  = w_q.act & (w_q.ph < PW'(HALF));

    assert_phase_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.act && !$past(w_q.act)) |-> (w_q.ph == '0))
        else $error("activation did not start at phase zero");

endmodule

// File: rtl/lkon_wake_gen.sv
module lkon_wake_gen
    import lkon_pkg::*;
#(
    parameter int PC_TIMEOUT     = 40,
    parameter int WAVE_PERIOD    = 8,
    parameter int CLASS_W        = 3,
    parameter int MAX_WAKE_CLASS = 4
) (
    input  logic               clk,
    input  logic               hw_rst_n,
    input  logic               link_pwr_on,
    input  logic               link_ctrl_bit,
    input  logic               pkt_wake_pulse,
    input  logic               bus_reset_pulse,
    input  logic               irq_port_evt,
    input  logic               irq_cfg_tmo,
    input  logic               irq_cbl_pwr,
    input  logic               irq_state_tmo,
    input  logic               irq_resume_en,
    input  logic               pwr_cycle_evt,
    input  logic [CLASS_W-1:0] pwr_class,
    input  logic               pad_in,
    output logic               wake_out,
    output logic               wake_oe,
    output logic               strap_legacy
);

    logic        link_idle;
    logic        irq_wake;
    logic        wake_req;
    logic        wave_act;
    irq_bits_t   irq;
    strap_mode_e strap_mode;

    assign link_idle = !(link_pwr_on && link_ctrl_bit);
    assign irq = '{port_evt:  irq_port_evt,
                   cfg_tmo:   irq_cfg_tmo,
                   cbl_pwr:   irq_cbl_pwr,
                   state_tmo: irq_state_tmo,
                   resume_en: irq_resume_en};

    lkon_src #(
        .PC_TIMEOUT    (PC_TIMEOUT),
        .CLASS_W       (CLASS_W),
        .MAX_WAKE_CLASS(MAX_WAKE_CLASS)
    ) u_src (
        .clk      (clk),
        .rst_n    (hw_rst_n),
        .link_idle(link_idle),
        .pkt_pulse(pkt_wake_pulse),
        .bus_rst  (bus_reset_pulse),
        .irq      (irq),
        .pc_evt   (pwr_cycle_evt),
        .pc_class (pwr_class),
        .irq_wake (irq_wake),
        .wake_req (wake_req)
    );

    lkon_wave #(
        .WAVE_PERIOD(WAVE_PERIOD)
    ) u_wave (
        .clk   (clk),
        .rst_n (hw_rst_n),
        .req   (wake_req),
        .active(wave_act),
        .level (wake_out)
    );

    lkon_strap u_strap (
        .clk       (clk),
        .rst_n     (hw_rst_n),
        .pad_in    (pad_in),
        .strap_mode(strap_mode),
        .pad_oe    (wake_oe)
    );

    assign strap_legacy = (strap_mode == STRAP_LEGACY);

    always_comb begin
        if (!hw_rst_n) begin
            assert_quiet_in_reset_R1: assert (!wake_out)
                else $error("wake output active in reset");
        end
    end

    assert_busy_link_blocks_R3: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $past(!link_idle) |-> !wave_act)
        else $error("wake active after busy link sampled");

    assert_pending_irq_wakes_R8: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (link_idle && irq_wake) |=> wave_act)
        else $error("pending interrupt did not activate wake");

endmodule

// File: tb/tb_lkon_wake_gen.sv
module tb_lkon_wake_gen;

    localparam int TB_TMO = 20;
    localparam int TB_PER = 8;

    logic clk = 1'b0;
    logic hw_rst_n, link_pwr_on, link_ctrl_bit, pkt_wake_pulse, bus_reset_pulse;
    logic irq_port_evt, irq_cfg_tmo, irq_cbl_pwr, irq_state_tmo, irq_resume_en;
    logic pwr_cycle_evt, pad_in;
    logic [2:0] pwr_class;
    logic wake_out, wake_oe, strap_legacy;

    int checks = 0;
    int failures = 0;
    int wph = 0;
    bit done = 1'b0;
    logic  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    lkon_wake_gen #(.PC_TIMEOUT(TB_TMO), .WAVE_PERIOD(TB_PER)) dut (
        .clk(clk), .hw_rst_n(hw_rst_n), .link_pwr_on(link_pwr_on),
        .link_ctrl_bit(link_ctrl_bit), .pkt_wake_pulse(pkt_wake_pulse),
        .bus_reset_pulse(bus_reset_pulse), .irq_port_evt(irq_port_evt),
        .irq_cfg_tmo(irq_cfg_tmo), .irq_cbl_pwr(irq_cbl_pwr),
        .irq_state_tmo(irq_state_tmo), .irq_resume_en(irq_resume_en),
        .pwr_cycle_evt(pwr_cycle_evt), .pwr_class(pwr_class), .pad_in(pad_in),
        .wake_out(wake_out), .wake_oe(wake_oe), .strap_legacy(strap_legacy)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: pops one expectation per cycle, after the edge settles
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(wake_out, e, t);
            chk(wake_oe, 1'b1, "R1");
        end
    end

    // driver helpers: called at a negedge after inputs are set
    task automatic active_step(input string tag);
        exp_q.push_back(wph < TB_PER / 2);
        tag_q.push_back(tag);
        wph = (wph + 1) % TB_PER;
        @(negedge clk);
    endtask

    task automatic idle_step(input string tag);
        exp_q.push_back(1'b0);
        tag_q.push_back(tag);
        wph = 0;
        @(negedge clk);
    endtask

    task automatic quiesce();
        link_pwr_on = 1'b1; link_ctrl_bit = 1'b1;
        pkt_wake_pulse = 0; bus_reset_pulse = 0; pwr_cycle_evt = 0; pwr_class = 0;
        irq_port_evt = 0; irq_cfg_tmo = 0; irq_cbl_pwr = 0; irq_state_tmo = 0; irq_resume_en = 0;
        idle_step("R7"); idle_step("R7");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        hw_rst_n = 0; pad_in = 1'b1;
        link_pwr_on = 1; link_ctrl_bit = 1;
        pkt_wake_pulse = 0; bus_reset_pulse = 0; pwr_cycle_evt = 0; pwr_class = 0;
        irq_port_evt = 0; irq_cfg_tmo = 0; irq_cbl_pwr = 0; irq_state_tmo = 0; irq_resume_en = 0;
        repeat (3) @(negedge clk);
        chk(wake_oe, 1'b0, "R1");
        chk(wake_out, 1'b0, "R1");
        hw_rst_n = 1; pad_in = 1'b0;
        @(negedge clk);
        chk(wake_oe, 1'b1, "R1");
        chk(strap_legacy, 1'b1, "R2");
        repeat (3) @(negedge clk);
        chk(strap_legacy, 1'b1, "R2");
        hw_rst_n = 0;
        repeat (2) @(negedge clk);
        chk(wake_oe, 1'b0, "R1");
        hw_rst_n = 1; pad_in = 1'b1;
        @(negedge clk);
        chk(strap_legacy, 1'b0, "R2");

        // R3: busy link blocks packet and power-cycle sources
        pkt_wake_pulse = 1; idle_step("R3");
        pkt_wake_pulse = 0; idle_step("R3"); idle_step("R3");
        pwr_cycle_evt = 1; pwr_class = 3'd2; idle_step("R3");
        pwr_cycle_evt = 0; idle_step("R3"); idle_step("R3");

        // R4/R5: packet wake with control bit cleared, full waveform
        link_ctrl_bit = 0;
        pkt_wake_pulse = 1; active_step("R4");
        pkt_wake_pulse = 0;
        for (int i = 0; i < 19; i++) active_step("R5");
        link_ctrl_bit = 1; idle_step("R7"); idle_step("R7");

        // R4: grouped interrupts need the resume enable
        link_pwr_on = 0;
        irq_cfg_tmo = 1; idle_step("R4"); idle_step("R4"); idle_step("R4");
        irq_resume_en = 1;
        for (int i = 0; i < 6; i++) active_step("R4");
        irq_cfg_tmo = 0; idle_step("R4"); idle_step("R4");
        irq_state_tmo = 1;
        for (int i = 0; i < 3; i++) active_step("R4");
        irq_state_tmo = 0; irq_cbl_pwr = 1;
        for (int i = 0; i < 3; i++) active_step("R4");
        irq_cbl_pwr = 0; irq_resume_en = 0; idle_step("R4");
        quiesce();

        // R6: bus reset cancels packet wake only
        link_pwr_on = 0;
        pkt_wake_pulse = 1; active_step("R4");
        pkt_wake_pulse = 0; active_step("R5"); active_step("R5");
        bus_reset_pulse = 1; idle_step("R6");
        bus_reset_pulse = 0; idle_step("R6"); idle_step("R6");
        irq_port_evt = 1; pkt_wake_pulse = 1; active_step("R4");
        pkt_wake_pulse = 0; active_step("R5"); active_step("R5");
        bus_reset_pulse = 1; active_step("R6");
        bus_reset_pulse = 0;
        for (int i = 0; i < 6; i++) active_step("R6");
        irq_port_evt = 0; idle_step("R6");
        quiesce();

        // R8: pending interrupt wakes when link goes idle
        irq_port_evt = 1;
        idle_step("R8"); idle_step("R8"); idle_step("R8");
        link_pwr_on = 0;
        for (int i = 0; i < 5; i++) active_step("R8");
        link_pwr_on = 1; idle_step("R7"); idle_step("R7");
        irq_port_evt = 0;
        quiesce();

        // R9: power-cycle-only wake times out; bus reset does not cut it
        link_pwr_on = 0;
        pwr_cycle_evt = 1; pwr_class = 3'd4; active_step("R4");
        pwr_cycle_evt = 0;
        for (int i = 0; i < TB_TMO - 1; i++) active_step("R9");
        idle_step("R9"); idle_step("R9"); idle_step("R9");
        pwr_cycle_evt = 1; pwr_class = 3'd5; idle_step("R4");
        pwr_cycle_evt = 0; idle_step("R4"); idle_step("R4");
        pwr_cycle_evt = 1; pwr_class = 3'd0; active_step("R4");
        pwr_cycle_evt = 0; active_step("R9");
        bus_reset_pulse = 1; active_step("R6");
        bus_reset_pulse = 0;
        for (int i = 0; i < TB_TMO - 3; i++) active_step("R9");
        idle_step("R9"); idle_step("R9");
        quiesce();

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule